// File: doc/BRIEF.md
# Bitstream Bandpass Rate Demodulator

This block turns the two single-bit outputs of a vibratory rate sensor's sigma-delta loops into signed angular-rate words. One stream carries the drive-mode oscillation and the other carries the sense-mode response. The clock runs at four times the resonance, so one clock is one sample. Each stream is mapped to +1/-1 and passes through its own resonator filter before the two are multiplied. Because the filtering comes first, quantization noise away from the resonance is removed before mixing and is not folded down to baseband. The resonator's poles sit at a quarter of the sample rate, and its zeros at DC and Nyquist, so the passband follows the resonance whenever the resonance-derived clock moves.

A programmable delay of 0 to 31 samples on the filtered drive reference sets the demodulation phase. With the right setting, the quadrature part of the sense signal averages to zero and the in-phase part gives the largest output. The product feeds a third-order cascaded integrator-comb decimator. Its ratio can be set from 16 to 256, and each rate word it produces is marked by a single-cycle strobe.

Top module: `gyro_rate_demod`

## Requirements
- R1: A synchronous active-high `rst` clears all filter, delay, mixer and decimator state. While `rst` is applied, and in the cycle after it, `rate_valid` is 0 and `rate_word` is 0.
- R2: Input bit 1 stands for +1 and bit 0 for -1. Each stream is filtered by y[n] = x[n] - x[n-2] - y[n-2] + floor(y[n-2] / 2^POLE_SHIFT), and the filter output is registered. A constant stream or an alternating 1/0 stream on both inputs therefore settles to a rate word near zero.
- R3: Each filter result is saturated to the signed DW-bit range (default -512..511) before it is stored.
- R4: The filtered drive value reaches the mixer delayed by `phase_sel` samples (0 to 31). With identical quarter-rate square waves on both inputs, `phase_sel`=0 gives a large positive rate and `phase_sel`=1 gives a rate near zero.
- R5: The mixer registers the product of the delayed drive value and the filtered sense value, shifted arithmetically right by MIX_SHIFT (default 0).
- R6: The decimator has three integrators followed by three combs. It runs at the ratio given by `dec_ratio`, clamped to the range 16..256, and produces one decimation instant per ratio samples.
- R7: A new `dec_ratio` is latched only at a decimation instant (and at reset). The period that is already running is not changed.
- R8: The first three decimation instants after reset update the combs but raise no strobe. The first `rate_valid` therefore appears 4*ratio clocks after reset is released.
- R9: At each strobed instant, `rate_word` takes the last comb output shifted arithmetically right by OUT_SHIFT (default 8) and saturated to 24-bit signed. `rate_valid` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the resonance |
| rst | input | 1 | Synchronous reset, active high |
| drive_bit | input | 1 | Drive-loop sigma-delta bit |
| sense_bit | input | 1 | Sense-loop sigma-delta bit |
| phase_sel | input | 5 | Drive reference delay in samples |
| dec_ratio | input | 9 | Requested decimation ratio, clamped to 16..256 |
| rate_valid | output | 1 | One-cycle strobe for a new rate word |
| rate_word | output | 24 | Signed demodulated rate |

## Verification
The decimator assertions assume the ratio never falls below 16, so strobes are always separated by idle cycles. The bench keeps every request, including deliberately out-of-range values, inside the 9-bit field so that the clamp decides the ratio. The delay and mixer checks assume `phase_sel` and the filtered values stay steady across the clock edge. The bench therefore changes every input only at the falling edge. Random phase and ratio changes occur only at 500-cycle block boundaries, so each setting stays in force for many samples.

// File: rtl/gdm_pkg.sv
package gdm_pkg;

  // Clamp a wide signed value into the signed range of w bits.
  function automatic logic signed [63:0] clip_s(input logic signed [63:0] v,
                                                 input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Bitstream symbol to arithmetic value.
  function automatic logic signed [63:0] bit_to_pm1(input logic b);
    return b ? 64'sd1 : -64'sd1;
  endfunction

endpackage

// File: rtl/gdm_biquad.sv
module gdm_biquad import gdm_pkg::*; #(
  parameter int DW         = 10,
  parameter int POLE_SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  output logic signed [DW-1:0] y
);

  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [1:0]    xd1, xd2;
  logic signed [DW-1:0] yd2;
  logic signed [63:0]   acc, acc_c;
  logic                 sat_hi, sat_lo;

  // x[n] - x[n-2] - y[n-2] + floor(y[n-2] / 2^POLE_SHIFT)
  always_comb begin
    acc    = bit_to_pm1(bit_in) - 64'(xd2) - 64'(yd2) + (64'(yd2) >>> POLE_SHIFT);
    acc_c  = clip_s(acc, DW);
    sat_hi = acc > acc_c;
    sat_lo = acc < acc_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xd1 <= '0;
      xd2 <= '0;
      y   <= '0;
      yd2 <= '0;
    end else begin
      xd1 <= bit_in ? 2'sd1 : -2'sd1;
      xd2 <= xd1;
      y   <= acc_c[DW-1:0];
      yd2 <= y;
    end
  end

  assert_sat_high_R3: assert property (@(posedge clk) disable iff (rst)
    sat_hi |=> (y == YMAX));
  assert_sat_low_R3: assert property (@(posedge clk) disable iff (rst)
    sat_lo |=> (y == YMIN));

endmodule

// File: rtl/gdm_phase_delay.sv
module gdm_phase_delay #(
  parameter int DW = 10,
  parameter int SW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] din,
  input  logic [SW-1:0]        sel,
  output logic signed [DW-1:0] dout
);

  localparam int NT = 2 ** SW;

  logic signed [DW-1:0] taps [NT];
  logic [1:0]           warm;

  assign taps[0] = din;

  for (genvar k = 1; k < NT; k++) begin : g_stage
    logic signed [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= taps[k-1];
    end
    assign taps[k] = q;
  end

  assign dout = taps[sel];

  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_tap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (dout == din));
  assert_tap_one_R4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && sel == SW'(1)) |-> (dout == $past(din)));

endmodule

// File: rtl/gdm_mixer.sv
module gdm_mixer #(
  parameter int DW        = 10,
  parameter int MIX_SHIFT = 0,
  parameter int MW        = 2 * DW - MIX_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [MW-1:0] p
);

  logic signed [2*DW-1:0] full;
  logic signed [2*DW-1:0] scaled;

  always_comb begin
    full   = (2*DW)'(a) * (2*DW)'(b);
    scaled = full >>> MIX_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else     p <= scaled[MW-1:0];
  end

  assert_mix_neg_R5: assert property (@(posedge clk) disable iff (rst)
    (a != '0 && b != '0 && (a[DW-1] ^ b[DW-1])) |=> p[MW-1]);
  assert_mix_pos_R5: assert property (@(posedge clk) disable iff (rst)
    (a[DW-1] == b[DW-1]) |=> !p[MW-1]);

endmodule

// File: rtl/gdm_cic_decim.sv
module gdm_cic_decim import gdm_pkg::*; #(
  parameter int IW        = 20,
  parameter int RW        = 9,
  parameter int RMIN      = 16,
  parameter int RMAX      = 256,
  parameter int ORDER     = 3,
  parameter int OUT_SHIFT = 8,
  parameter int OW        = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] din,
  input  logic [RW-1:0]        ratio_in,
  output logic                 valid,
  output logic signed [OW-1:0] dout
);

  localparam int CW = IW + ORDER * $clog2(RMAX);
  localparam int FW = $clog2(ORDER + 1);

  logic signed [CW-1:0] integ [ORDER];
  logic signed [CW-1:0] zdel  [ORDER];
  logic signed [CW-1:0] cmb   [ORDER+1];
  logic [RW-1:0]        cnt, ratio_q;
  logic [FW-1:0]        fill;
  logic                 tick;
  logic signed [63:0]   shaped;

  function automatic logic [RW-1:0] clamp_ratio(input logic [RW-1:0] r);
    if (r < RW'(RMIN)) return RW'(RMIN);
    if (r > RW'(RMAX)) return RW'(RMAX);
    return r;
  endfunction

  assign tick = (cnt == ratio_q - RW'(1));

  assign cmb[0] = integ[ORDER-1];
  for (genvar s = 0; s < ORDER; s++) begin : g_comb
    assign cmb[s+1] = cmb[s] - zdel[s];
  end

  assign shaped = clip_s(64'(cmb[ORDER]) >>> OUT_SHIFT, OW);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < ORDER; s++) begin
        integ[s] <= '0;
        zdel[s]  <= '0;
      end
      cnt     <= '0;
      ratio_q <= clamp_ratio(ratio_in);
      fill    <= '0;
      valid   <= 1'b0;
      dout    <= '0;
    end else begin
      integ[0] <= integ[0] + CW'(din);
      for (int s = 1; s < ORDER; s++) integ[s] <= integ[s] + integ[s-1];
      if (tick) begin
        for (int s = 0; s < ORDER; s++) zdel[s] <= cmb[s];
        cnt     <= '0;
        ratio_q <= clamp_ratio(ratio_in);
        dout    <= shaped[OW-1:0];
        valid   <= (fill == FW'(ORDER));
        if (fill != FW'(ORDER)) fill <= fill + FW'(1);
      end else begin
        cnt   <= cnt + RW'(1);
        valid <= 1'b0;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!valid && dout == '0));
  assert_count_in_period_R6: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio_q);
  assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ratio_q));
  assert_strobe_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(tick));
  assert_fill_suppress_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && fill != FW'(ORDER)) |=> !valid);
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

endmodule

// File: rtl/gyro_rate_demod.sv
module gyro_rate_demod #(
  parameter int DW         = 10,
  parameter int POLE_SHIFT = 8,
  parameter int PHASE_BITS = 5,
  parameter int MIX_SHIFT  = 0,
  parameter int RATIO_MIN  = 16,
  parameter int RATIO_MAX  = 256,
  parameter int CIC_ORDER  = 3,
  parameter int OUT_SHIFT  = 8,
  parameter int OUT_W      = 24,
  localparam int MW        = 2 * DW - MIX_SHIFT,
  localparam int RW        = $clog2(RATIO_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    drive_bit,
  input  logic                    sense_bit,
  input  logic [PHASE_BITS-1:0]   phase_sel,
  input  logic [RW-1:0]           dec_ratio,
  output logic                    rate_valid,
  output logic signed [OUT_W-1:0] rate_word
);

  logic signed [DW-1:0] drive_filt;
  logic signed [DW-1:0] sense_filt;
  logic signed [DW-1:0] drive_ref;
  logic signed [MW-1:0] mix_out;

  gdm_biquad #(.DW(DW), .POLE_SHIFT(POLE_SHIFT)) u_bq_drive (
    .clk(clk), .rst(rst), .bit_in(drive_bit), .y(drive_filt));

  gdm_biquad #(.DW(DW), .POLE_SHIFT(POLE_SHIFT)) u_bq_sense (
    .clk(clk), .rst(rst), .bit_in(sense_bit), .y(sense_filt));

  gdm_phase_delay #(.DW(DW), .SW(PHASE_BITS)) u_phase (
    .clk(clk), .rst(rst), .din(drive_filt), .sel(phase_sel), .dout(drive_ref));

  gdm_mixer #(.DW(DW), .MIX_SHIFT(MIX_SHIFT), .MW(MW)) u_mix (
    .clk(clk), .rst(rst), .a(drive_ref), .b(sense_filt), .p(mix_out));

  gdm_cic_decim #(
    .IW(MW), .RW(RW), .RMIN(RATIO_MIN), .RMAX(RATIO_MAX),
    .ORDER(CIC_ORDER), .OUT_SHIFT(OUT_SHIFT), .OW(OUT_W)
  ) u_cic (
    .clk(clk), .rst(rst), .din(mix_out), .ratio_in(dec_ratio),
    .valid(rate_valid), .dout(rate_word));

endmodule

// File: tb/gyro_rate_demod_tb.sv
`timescale 1ns/1ps
module gyro_rate_demod_tb;
  localparam int W = 10, K = 8, MSH = 0, CW = 44, OSH = 8, OW = 24;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 drive_bit = 1'b0, sense_bit = 1'b0;
  logic [4:0]           phase_sel = '0;
  logic [8:0]           dec_ratio = 9'd16;
  logic                 rate_valid;
  logic signed [OW-1:0] rate_word;

  gyro_rate_demod u_dut (
    .clk(clk), .rst(rst), .drive_bit(drive_bit), .sense_bit(sense_bit),
    .phase_sel(phase_sel), .dec_ratio(dec_ratio),
    .rate_valid(rate_valid), .rate_word(rate_word));

  always #2.5 clk = ~clk;

  int checks = 0, errs = 0, mode = 0, nidx = 0;
  bit done = 1'b0;

  // reference state of the chain
  longint m_xd1 [2], m_xd2 [2], m_y [2], m_yd2 [2], m_line [32];
  longint m_p, m_i1, m_i2, m_i3, m_z1, m_z2, m_z3, m_out;
  int     m_cnt, m_rq, m_fill;
  bit     m_valid;

  function automatic longint limit(longint v, int w);
    longint top = (longint'(1) <<< (w - 1)) - 1;
    if (v > top) return top;
    if (v < -top - 1) return -top - 1;
    return v;
  endfunction

  function automatic longint modw(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint sym(logic b);
    return b ? 1 : -1;
  endfunction

  function automatic int ratio_of(int r);
    return (r < 16) ? 16 : (r > 256) ? 256 : r;
  endfunction

  task automatic model_step(logic r, logic d, logic s, int ph, int dr);
    longint nyd, nys, tap, np, c1, c2, c3;
    if (r) begin
      for (int i = 0; i < 2; i++) begin m_xd1[i] = 0; m_xd2[i] = 0; m_y[i] = 0; m_yd2[i] = 0; end
      for (int i = 0; i < 32; i++) m_line[i] = 0;
      m_p = 0; m_i1 = 0; m_i2 = 0; m_i3 = 0; m_z1 = 0; m_z2 = 0; m_z3 = 0;
      m_out = 0; m_cnt = 0; m_fill = 0; m_valid = 0; m_rq = ratio_of(dr);
      return;
    end
    nyd = limit(sym(d) - m_xd2[0] - m_yd2[0] + (m_yd2[0] >>> K), W);
    nys = limit(sym(s) - m_xd2[1] - m_yd2[1] + (m_yd2[1] >>> K), W);
    tap = (ph == 0) ? m_y[0] : m_line[ph];
    np  = (tap * m_y[1]) >>> MSH;
    if (m_cnt == m_rq - 1) begin
      c1 = modw(m_i3 - m_z1, CW); c2 = modw(c1 - m_z2, CW); c3 = modw(c2 - m_z3, CW);
      m_out = limit(c3 >>> OSH, OW);
      m_valid = (m_fill == 3);
      if (m_fill < 3) m_fill++;
      m_z1 = m_i3; m_z2 = c1; m_z3 = c2;
      m_cnt = 0; m_rq = ratio_of(dr);
    end else begin
      m_cnt++; m_valid = 0;
    end
    m_i3 = modw(m_i3 + m_i2, CW);
    m_i2 = modw(m_i2 + m_i1, CW);
    m_i1 = modw(m_i1 + m_p, CW);
    m_p  = np;
    for (int i = 31; i >= 2; i--) m_line[i] = m_line[i-1];
    m_line[1] = m_y[0];
    m_xd2[0] = m_xd1[0]; m_xd1[0] = sym(d); m_yd2[0] = m_y[0]; m_y[0] = nyd;
    m_xd2[1] = m_xd1[1]; m_xd1[1] = sym(s); m_yd2[1] = m_y[1]; m_y[1] = nys;
  endtask

  task automatic chk(bit ok, string tag, longint got, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic sq(int n);
    return (n % 4) < 2;
  endfunction

  // apply one sample at the falling edge, then compare after the next rising edge
  task automatic next_cycle();
    logic d, s;
    case (mode)
      0: begin d = 1'($urandom % 2); s = 1'($urandom % 2); end
      1: begin d = sq(nidx); s = sq(nidx); end
      2: begin d = sq(nidx); s = !sq(nidx); end
      3: begin d = sq(nidx) ^ ($urandom % 8 == 0); s = sq(nidx) ^ ($urandom % 8 == 0); end
      4: begin d = 1'b1; s = 1'b1; end
      default: begin d = 1'(nidx % 2); s = 1'(nidx % 2); end
    endcase
    nidx++;
    drive_bit = d; sense_bit = s;
    @(negedge clk);
    model_step(rst, d, s, int'(phase_sel), int'(dec_ratio));
    chk(rate_valid === m_valid, "R6 R8 R9 rate_valid", longint'(rate_valid), longint'(m_valid));
    if (m_valid)
      chk(longint'(rate_word) == m_out, "R2 R3 R4 R5 R6 R9 rate_word", longint'(rate_word), m_out);
  endtask

  task automatic wait_valid();
    int n = 0;
    do begin next_cycle(); n++; end while (!rate_valid && n < 5000);
  endtask

  task automatic gap(int pre, int exp, string tag);
    int n = pre;
    do begin next_cycle(); n++; end while (!rate_valid && n < 5000);
    chk(n == exp, tag, n, exp);
  endtask

  function automatic longint mag(longint v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin
    int n;
    void'($urandom(32'd9127));
    @(negedge clk);
    // R1: reset state
    rst = 1'b1; dec_ratio = 9'd16; mode = 1;
    repeat (3) next_cycle();
    chk(rate_valid == 1'b0 && rate_word == '0, "R1 outputs in reset", longint'(rate_word), 0);
    // R8: first strobe after four ratio periods
    rst = 1'b0; n = 0;
    do begin next_cycle(); n++; end while (!rate_valid && n < 1000);
    chk(n == 64, "R8 first strobe delay", n, 64);
    // R4: in-phase tone gives a large positive rate (R3 saturation inside model)
    repeat (8000) next_cycle();
    wait_valid();
    chk(rate_word > 100000, "R4 in-phase gain", longint'(rate_word), 100000);
    // R4: one sample of delay turns the pair into quadrature
    phase_sel = 5'd1;
    repeat (8000) next_cycle();
    wait_valid();
    chk(mag(longint'(rate_word)) <= 64, "R4 quadrature rejection", longint'(rate_word), 0);
    // R9: output saturation, both signs
    phase_sel = 5'd0; dec_ratio = 9'd256;
    repeat (8000) next_cycle();
    wait_valid();
    chk(longint'(rate_word) == 8388607, "R9 positive saturation", longint'(rate_word), 8388607);
    mode = 2;
    repeat (8000) next_cycle();
    wait_valid();
    chk(longint'(rate_word) == -8388608, "R9 negative saturation", longint'(rate_word), -8388608);
    // R2: DC and Nyquist streams are rejected
    dec_ratio = 9'd64; mode = 4;
    repeat (8000) next_cycle();
    wait_valid();
    chk(mag(longint'(rate_word)) <= 16, "R2 DC rejection", longint'(rate_word), 0);
    mode = 5;
    repeat (8000) next_cycle();
    wait_valid();
    chk(mag(longint'(rate_word)) <= 16, "R2 Nyquist rejection", longint'(rate_word), 0);
    // R7 and R6: ratio latched at period boundaries, clamped to 16..256
    mode = 0; dec_ratio = 9'd16;
    wait_valid(); wait_valid(); wait_valid();
    repeat (3) next_cycle();
    dec_ratio = 9'd100;
    gap(3, 16, "R7 running period kept");
    gap(0, 100, "R7 new ratio after boundary");
    dec_ratio = 9'd3;
    gap(0, 100, "R7 period before low clamp");
    gap(0, 16, "R6 low clamp to 16");
    dec_ratio = 9'd400;
    gap(0, 16, "R6 period before high clamp");
    gap(0, 256, "R6 high clamp to 256");
    // random blocks: noisy tones and random bits, random phase and ratio
    for (int b = 0; b < 80; b++) begin
      mode = ($urandom % 2 == 0) ? 0 : 3;
      phase_sel = 5'($urandom % 32);
      dec_ratio = ($urandom % 2 == 0) ? 9'($urandom % 512) : 9'(16 + $urandom % 48);
      repeat (500) next_cycle();
    end
    // R1 and R8 again after a reset in mid-run
    dec_ratio = 9'd20; rst = 1'b1;
    repeat (2) next_cycle();
    chk(rate_valid == 1'b0 && rate_word == '0, "R1 outputs after mid-run reset", longint'(rate_word), 0);
    rst = 1'b0; n = 0;
    do begin next_cycle(); n++; end while (!rate_valid && n < 1000);
    chk(n == 80, "R8 first strobe after mid-run reset", n, 80);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R9 got no completion exp completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule